// File: doc/BRIEF.md
# I2C Register Bank Target

This block is an I2C target that gives a bus host read and write access to a small bank of byte-wide registers. It oversamples SCL and SDA with a fast system clock and recognises START, repeated START and STOP on the synchronised lines. The first byte after a START is checked against a fixed 7-bit device address. A matching write header is followed by a register-address byte that loads an internal pointer. Every data byte after that is stored at the pointer, and the pointer then advances. A repeated START with the read header streams bytes out, starting at the current pointer. A repeated START with the write header begins a fresh register-address phase in the same transaction.

The target drives SDA only by pulling it low, through a single drive-enable output. The bank holds `NUM_REGS` bytes. The pointer stops advancing one place past the last register. From there, reads give 00h, and writes are acknowledged but not stored. Control is one state machine with these states: IDLE, DEVADDR (shift the header), DEVACK, REGADDR, REGACK, WDATA, WACK, RDATA, RACK (sample the host's acknowledge) and IGNORE. START moves from any state to DEVADDR and STOP moves from any state to IDLE. DEVADDR moves to DEVACK on a match and to IGNORE otherwise. DEVACK moves to RDATA for a read header and to REGADDR for a write header. REGADDR moves to REGACK and then to WDATA. WDATA and WACK alternate. RDATA moves to RACK after 8 bits. RACK returns to RDATA on an acknowledge and moves to IGNORE on a not-acknowledge.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset the SDA drive enable is 0 (line released).
- R2: The target acknowledges a header byte only when its upper 7 bits equal 0110011b, so 66h for a write and 67h for a read. After any other header it drives nothing until the next START or STOP.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Either one, even in the middle of a byte, clears the bit count. After a START the next 8 bits are taken as a new header.
- R4: After a 66h header, the next byte loads the register pointer. Each following byte is acknowledged and stored at the pointer.
- R5: A repeated START followed by 67h starts a read at the current pointer value. Read data is sent MSB first.
- R6: The pointer advances by one after each data byte is transferred, in both directions.
- R7: The pointer saturates at NUM_REGS (10h by default). Register-address bytes at or above 10h load 10h. A read at the saturated pointer returns 00h.
- R8: A write at the saturated pointer is acknowledged, changes no register, and does not wrap to address 00h.
- R9: When the host does not acknowledge a read byte, the target releases SDA and keeps it released until the next START.
- R10: A repeated START followed by 66h begins a new register-address phase, and the writes after it land at the new address.
- R11: The SDA drive enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The in-RTL assertions check several properties on every clock. The SDA enable moves only during the SCL low phase. START and STOP put the machine into its header-reception and idle states. The pointer never exceeds its saturation value and steps by exactly one after each stored byte. Stores never target an address outside the bank. Other behaviours can be shown only by the bench's bus transactions, because they depend on whole-byte data. These are: address match and mismatch, consecutive stores and reads, 00h returned past the end, discarded out-of-range writes, release after a not-acknowledge, restart in the middle of a byte, and compound writes after a repeated START.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_REGADDR,
        ST_REGACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_q;
    logic [DEPTH-1:0] sda_q;
    logic             scl_p;
    logic             sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[DEPTH-2:0], scl_i};
            sda_q <= {sda_q[DEPTH-2:0], sda_i};
        end
    end

    assign scl_s     = scl_q[DEPTH-2];
    assign sda_s     = sda_q[DEPTH-2];
    assign scl_p     = scl_q[DEPTH-1];
    assign sda_p     = sda_q[DEPTH-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store #(
    parameter int NUM_REGS = 16,
    parameter int PW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data
);
    localparam int IW = $clog2(NUM_REGS);

    logic [7:0] mem [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= 8'h00;
        end else if (wr_en) begin
            mem[addr[IW-1:0]] <= wr_data;
        end
    end

    assign rd_data = (addr < PW'(NUM_REGS)) ? mem[addr[IW-1:0]] : 8'h00;

    // R8: the controller never issues a store outside the bank
    a_r8_store_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (addr < PW'(NUM_REGS)));
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h33,
    parameter int         NUM_REGS = 16,
    parameter int         PW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] PTR_END = PW'(NUM_REGS);

    tgt_state_e    state_q, state_d;
    logic [7:0]    shreg;
    logic [7:0]    tx;
    logic [3:0]    cnt;
    logic          mack_q;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_inc;
    logic          byte_done;
    logic          addr_hit;
    logic          bus_evt;

    assign byte_done = scl_fall && (cnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign bus_evt   = start_det || stop_det;
    assign ptr_inc   = (ptr_q == PTR_END) ? ptr_q : ptr_q + 1'b1;
    assign ptr       = ptr_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_DEVADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_DEVADDR: if (byte_done) state_d = addr_hit ? ST_DEVACK : ST_IGNORE;
                ST_DEVACK:  if (scl_fall)  state_d = shreg[0] ? ST_RDATA : ST_REGADDR;
                ST_REGADDR: if (byte_done) state_d = ST_REGACK;
                ST_REGACK:  if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:   if (byte_done) state_d = ST_WACK;
                ST_WACK:    if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:   if (scl_fall && cnt == 4'd7) state_d = ST_RACK;
                ST_RACK:    if (scl_fall)  state_d = mack_q ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:  state_d = ST_IGNORE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: shifter, bit counter, pointer, transmit byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= 8'h00;
            tx     <= 8'h00;
            cnt    <= 4'd0;
            mack_q <= 1'b0;
            ptr_q  <= '0;
        end else if (bus_evt) begin
            cnt <= 4'd0;
        end else begin
            unique case (state_q)
                ST_DEVADDR: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_done) begin
                        cnt <= 4'd0;
                    end
                end
                ST_REGADDR: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_done) begin
                        cnt   <= 4'd0;
                        ptr_q <= (shreg >= 8'(NUM_REGS)) ? PTR_END : PW'(shreg);
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_done) begin
                        cnt   <= 4'd0;
                        ptr_q <= ptr_inc;
                    end
                end
                ST_DEVACK: begin
                    if (scl_fall && shreg[0]) begin
                        tx  <= rd_data;
                        cnt <= 4'd0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            cnt   <= 4'd0;
                            ptr_q <= ptr_inc;
                        end else begin
                            tx  <= {tx[6:0], 1'b0};
                            cnt <= cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall) tx <= rd_data;
                end
                ST_IDLE, ST_REGACK, ST_WACK, ST_IGNORE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_DEVACK, ST_REGACK, ST_WACK: sda_oe = 1'b1;
            ST_RDATA:                      sda_oe = ~tx[7];
            default:                       sda_oe = 1'b0;
        endcase
        wr_en   = (state_q == ST_WDATA) && byte_done && !bus_evt && (ptr_q != PTR_END);
        wr_data = shreg;
    end

    // R11: SDA drive only moves during the SCL low phase
    a_r11_drive_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
    // R3: START re-arms header reception with a cleared bit count
    a_r3_start_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_DEVADDR) && (cnt == 4'd0));
    // R3: STOP returns to idle with SDA released
    a_r3_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE) && !sda_oe);
    // R7: pointer saturates
    a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_END);
    // R6: each stored byte advances the pointer by one
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr_q == PW'($past(ptr_q) + 1'b1)));
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h33,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int PW = $clog2(NUM_REGS + 1);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [7:0]    wr_data, rd_data;
    logic [PW-1:0] ptr;

    i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PW(PW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ptr       (ptr)
    );

    i2c_reg_store #(.NUM_REGS(NUM_REGS), .PW(PW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (ptr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );
endmodule

// File: tb/tb_i2c_regbank_target.sv
module tb_i2c_regbank_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WDOG       = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regbank_target dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t       exp_q[$];
    logic [7:0] got_val;
    event       got_ev;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always begin
        exp_t e;
        @(got_ev);
        if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard-empty", int'(got_val), 0);
        end else begin
            e = exp_q.pop_front();
            check(got_val == e.val, e.tag, int'(got_val), int'(e.val));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic wbit(input bit b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0;
    endtask

    task automatic rbit(output bit b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line; wq();
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic send_chk(input logic [7:0] d, input bit exp_ack, input string tag);
        bit ack;
        send_byte(d, ack);
        check(ack == exp_ack, tag, int'(ack), int'(exp_ack));
    endtask

    task automatic recv_byte(input bit mack, input logic [7:0] expv, input string tag);
        exp_t e;
        bit   b;
        logic [7:0] d;
        e.val = expv;
        e.tag = tag;
        exp_q.push_back(e);
        d = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        got_val = d;
        ->got_ev;
        wbit(mack ? 1'b0 : 1'b1);
    endtask

    initial begin
        bit b;
        bit all_high;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wq();
        check(sda_oe == 1'b0, "R1 released after reset", int'(sda_oe), 0);

        // R4: write three bytes from 03h
        bus_start();
        send_chk(8'h66, 1'b1, "R2 write header ack");
        send_chk(8'h03, 1'b1, "R4 reg address ack");
        send_chk(8'hA1, 1'b1, "R4 data ack");
        send_chk(8'hA2, 1'b1, "R4 data ack");
        send_chk(8'hA3, 1'b1, "R4 data ack");
        bus_stop();

        // R5/R6: read back after repeated START
        bus_start();
        send_chk(8'h66, 1'b1, "R2 write header ack");
        send_chk(8'h03, 1'b1, "R4 reg address ack");
        bus_start();
        send_chk(8'h67, 1'b1, "R5 read header ack");
        recv_byte(1'b1, 8'hA1, "R5 first read at pointer");
        recv_byte(1'b1, 8'hA2, "R6 pointer advance");
        recv_byte(1'b0, 8'hA3, "R6 pointer advance");
        // R9: released after NACK, while SCL keeps toggling
        all_high = 1'b1;
        for (int i = 0; i < 9; i++) begin
            rbit(b);
            if (!b) all_high = 1'b0;
        end
        check(all_high, "R9 released after nack", int'(all_high), 1);
        bus_stop();

        // R2: foreign address is ignored
        bus_start();
        send_chk(8'h68, 1'b0, "R2 mismatch no ack");
        send_chk(8'h00, 1'b0, "R2 ignored after mismatch");
        bus_stop();

        // R8/R10: writes past end, then compound write
        bus_start();
        send_chk(8'h66, 1'b1, "R2 write header ack");
        send_chk(8'h0E, 1'b1, "R4 reg address ack");
        send_chk(8'h5E, 1'b1, "R4 data ack");
        send_chk(8'h5F, 1'b1, "R4 data ack");
        send_chk(8'h77, 1'b1, "R8 write past end acked");
        bus_start();
        send_chk(8'h66, 1'b1, "R10 compound write header ack");
        send_chk(8'h05, 1'b1, "R10 new reg address ack");
        send_chk(8'h11, 1'b1, "R10 compound data ack");
        bus_stop();

        // R7: read across end of bank
        bus_start();
        send_chk(8'h66, 1'b1, "R2 write header ack");
        send_chk(8'h0E, 1'b1, "R4 reg address ack");
        bus_start();
        send_chk(8'h67, 1'b1, "R5 read header ack");
        recv_byte(1'b1, 8'h5E, "R5 read at 0E");
        recv_byte(1'b1, 8'h5F, "R6 read at 0F");
        recv_byte(1'b1, 8'h00, "R7 read past end");
        recv_byte(1'b0, 8'h00, "R7 saturated read");
        bus_stop();

        // R8 no wrap, R10 compound data landed
        bus_start();
        send_chk(8'h66, 1'b1, "R2 write header ack");
        send_chk(8'h00, 1'b1, "R4 reg address ack");
        bus_start();
        send_chk(8'h67, 1'b1, "R5 read header ack");
        recv_byte(1'b1, 8'h00, "R8 no wrap to 00");
        recv_byte(1'b1, 8'h00, "R6 read at 01");
        recv_byte(1'b1, 8'h00, "R6 read at 02");
        recv_byte(1'b1, 8'hA1, "R6 read at 03");
        recv_byte(1'b1, 8'hA2, "R6 read at 04");
        recv_byte(1'b0, 8'h11, "R10 compound data stored");
        bus_stop();

        // R3: START in the middle of a header byte
        bus_start();
        wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b0);
        bus_start();
        send_chk(8'h66, 1'b1, "R3 header after mid-byte start");
        send_chk(8'h0F, 1'b1, "R4 reg address ack");
        bus_start();
        send_chk(8'h67, 1'b1, "R5 read header ack");
        recv_byte(1'b0, 8'h5F, "R3 read after restart");
        bus_stop();

        // R7: register address above end of bank
        bus_start();
        send_chk(8'h66, 1'b1, "R2 write header ack");
        send_chk(8'h20, 1'b1, "R7 high reg address ack");
        bus_start();
        send_chk(8'h67, 1'b1, "R5 read header ack");
        recv_byte(1'b0, 8'h00, "R7 read from clamped pointer");
        bus_stop();

        wq();
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule